// File: doc/BRIEF.md
# Chainable Dual Match Timer

This block holds two up-counters of `W` bits each. Each counter has its own compare register. A counter advances by one on each clock-enable pulse from its chosen source. That source is one of several prescaler taps or a synchronized external event pin. When the count equals the compare value on an advancing pulse, the counter drops to zero and raises a one-cycle match request. If pulse mode is on, the match also flips a square-wave output pin. Software writes control words and compare values through a simple write port, and both counts are always visible on output ports.

A chain bit in the first timer's control word joins the two counters into one counter of `2*W` bits. The upper half advances on the carry out of the lower half. The pair clears when both halves equal their compare values together. In this mode only the first timer's control word and match request are in effect.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts are 0 and both match requests and both pulse outputs are low.
- R2: Write port address map: `wr_addr[1]` selects the timer and `wr_addr[0]` selects control (0) or compare (1). Control word bits are run `[0]`, source select `[2:1]`, pulse mode `[3]` and chain `[4]`, where chain exists in timer 0 only. Writing a control word with run=1 sets the count to 0 on that edge. The count then rises by one per advancing pulse.
- R3: While run=0 the count holds its value, whatever the source enables do.
- R4: An advancing pulse that arrives while count equals compare clears the count to 0 and sets the match request high for that one cycle. A compare value of all ones lets the count reach all ones before it clears.
- R5: A compare write is used for the very next advancing pulse.
- R6: Source select values 0, 1 and 2 pick `tap_en[0]`, `tap_en[1]` and `tap_en[2]`. Value 3 picks the external event pin, and the taps are then ignored.
- R7: The event pin passes through two synchronizer flops. Each rising edge advances the count exactly once, no matter how long the pin stays high.
- R8: With pulse mode on, each match toggles that timer's pulse output. With pulse mode off, the pulse output does not change.
- R9: In chain mode the upper count advances when the lower count passes from all ones to zero. The pair clears together on a full-width match, and only `irq_o[0]` fires.
- R10: In chain mode, writes to timer 1's control word have no effect on the upper count, and `irq_o[1]` stays low.
- R11: When chain is off, the two timers count, match and raise requests independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_en | input | NTAP | Prescaler tap clock enables |
| evt_in | input | 2 | Asynchronous external event pins, one per timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W | Write data |
| irq_o | output | 2 | One-cycle match requests |
| pulse_o | output | 2 | Square-wave outputs |
| cnt_lo_o | output | W | Timer 0 count (lower half when chained) |
| cnt_hi_o | output | W | Timer 1 count (upper half when chained) |

## Verification
The assertions take reset to be held for at least one edge before any register is written. They treat the chain bit as quasi-static while carries are in flight, and they assume the event pins change no faster than the synchronizer can follow. The stimulus changes configuration only while the taps are held low, switches the chain bit with run cleared before starting the pair, and keeps every event level for three or more cycles. Tap enables are driven from negative edges for exact counts of advancing pulses, so each expected count is plain arithmetic.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             chain;
    logic             pulse;
    logic [SEL_W-1:0] sel;
    logic             run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic ADR_CTRL = 1'b0;
  localparam logic ADR_CMP  = 1'b1;

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R7: one advance per edge
  a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         step_i,
  input  logic         wipe_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] count_o,
  output logic         eq_o,
  output logic         top_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                 count_q <= '0;
    else if (wipe_i)         count_q <= '0;
    else if (run_i && step_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign eq_o    = (count_q == cmp_i);
  assign top_o   = (count_q == ALL_ONES);

  // R3: stopped counter keeps its value
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wipe_i) |=> $stable(count_q));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NTAP = (1 << SEL_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTAP-1:0] tap_en,
  input  logic [1:0]      evt_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  output logic [1:0]      irq_o,
  output logic [1:0]      pulse_o,
  output logic [W-1:0]    cnt_lo_o,
  output logic [W-1:0]    cnt_hi_o
);

  localparam int unsigned NCH = 2;

  tmr_ctrl_t      ctrl_q [NCH];
  logic [W-1:0]   cmp_q  [NCH];
  logic [NCH-1:0] evt_rise, tick, start;
  logic [NCH-1:0] run_u, step_u, wipe_u, eq_u, top_u, match;
  logic [W-1:0]   cnt_u  [NCH];
  logic [NCH-1:0] irq_q, pulse_q;
  logic           chain, start_chain;

  tmr_ctrl_t wr_ctrl;
  assign wr_ctrl = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q[g] <= '0;
          cmp_q[g]  <= '0;
        end else if (wr_en && wr_addr[1] == g[0]) begin
          if (wr_addr[0] == ADR_CTRL) ctrl_q[g] <= wr_ctrl;
          else                        cmp_q[g]  <= wr_data;
        end
      end

      assign start[g] = wr_en && (wr_addr[1] == g[0]) &&
                        (wr_addr[0] == ADR_CTRL) && wr_ctrl.run;

      tmr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (evt_in[g]),
        .rise_o(evt_rise[g])
      );

      always_comb begin
        tick[g] = evt_rise[g];
        for (int k = 0; k < NTAP; k++) begin
          if (ctrl_q[g].sel == SEL_W'(k)) tick[g] = tap_en[k];
        end
      end

      tmr_count #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_u[g]),
        .step_i (step_u[g]),
        .wipe_i (wipe_u[g]),
        .cmp_i  (cmp_q[g]),
        .count_o(cnt_u[g]),
        .eq_o   (eq_u[g]),
        .top_o  (top_u[g])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          irq_q[g]   <= 1'b0;
          pulse_q[g] <= 1'b0;
        end else begin
          irq_q[g] <= match[g];
          if (match[g] && ctrl_q[g].pulse) pulse_q[g] <= ~pulse_q[g];
        end
      end
    end
  endgenerate

  assign chain       = ctrl_q[0].chain;
  assign start_chain = start[0] && wr_ctrl.chain;

  // lower / single timer 0
  assign run_u[0]  = ctrl_q[0].run;
  assign step_u[0] = tick[0];
  assign match[0]  = ctrl_q[0].run && tick[0] &&
                     (chain ? (eq_u[0] && eq_u[1]) : eq_u[0]);
  assign wipe_u[0] = start[0] || match[0];

  // upper / single timer 1
  assign run_u[1]  = chain ? ctrl_q[0].run : ctrl_q[1].run;
  assign step_u[1] = chain ? (tick[0] && top_u[0]) : tick[1];
  assign match[1]  = !chain && ctrl_q[1].run && tick[1] && eq_u[1];
  assign wipe_u[1] = chain ? (start[0] || match[0])
                           : (start[1] || match[1] || start_chain);

  assign irq_o    = irq_q;
  assign pulse_o  = pulse_q;
  assign cnt_lo_o = cnt_u[0];
  assign cnt_hi_o = cnt_u[1];

  // R4: a match request always leaves the lower count at zero
  a_r4_irq_zero: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |-> (cnt_lo_o == '0));

  // R8: pulse output only moves together with a match request
  a_r8_pulse_with_irq: assert property (@(posedge clk) disable iff (rst)
    !$stable(pulse_o[0]) |-> irq_o[0]);

  // R10: upper request stays silent while chained
  a_r10_hi_silent: assert property (@(posedge clk) disable iff (rst)
    $past(chain) |-> !irq_o[1]);

  // R9: lower wrap carries into the upper half
  a_r9_carry: assert property (@(posedge clk) disable iff (rst)
    (chain && ctrl_q[0].run && tick[0] && top_u[0] && !match[0] && !start[0])
      |=> (cnt_hi_o == $past(cnt_hi_o) + 1'b1));

endmodule

// File: tb/tmr_pair_bench.sv
`timescale 1ns/1ps
module tmr_pair_bench;

  localparam int W = 8;
  localparam int NTAP = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NTAP-1:0] tap_en = '0;
  logic [1:0]      evt_in = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [W-1:0]    wr_data = '0;
  logic [1:0]      irq_o, pulse_o;
  logic [W-1:0]    cnt_lo_o, cnt_hi_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tmr_pair #(.W(W), .NTAP(NTAP)) u_tmr_pair (
    .clk(clk), .rst(rst), .tap_en(tap_en), .evt_in(evt_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_o(irq_o), .pulse_o(pulse_o), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input logic [NTAP-1:0] mask, input int n);
    tap_en = mask;
    for (int i = 0; i < n; i++) @(negedge clk);
    tap_en = '0;
  endtask

  task automatic evt_pulse(input int hi, input int lo);
    evt_in[0] = 1'b1;
    for (int i = 0; i < hi; i++) @(negedge clk);
    evt_in[0] = 1'b0;
    for (int i = 0; i < lo; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 lo", cnt_lo_o, 0);
    chk("R1 hi", cnt_hi_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 pulse", pulse_o, 0);
  endtask

  task automatic t_start_stop;
    wr(2'b01, 8'd200);
    wr(2'b00, 8'h01);
    chk("R2 cleared", cnt_lo_o, 0);
    ticks(3'b001, 4);
    chk("R2 count", cnt_lo_o, 4);
    wr(2'b00, 8'h00);
    ticks(3'b111, 6);
    chk("R3 hold", cnt_lo_o, 4);
    wr(2'b00, 8'h01);
    chk("R2 restart clears", cnt_lo_o, 0);
  endtask

  task automatic t_match;
    wr(2'b01, 8'd3);
    wr(2'b00, 8'h01);
    ticks(3'b001, 3);
    chk("R4 at cmp", cnt_lo_o, 3);
    chk("R4 no irq yet", irq_o[0], 0);
    ticks(3'b001, 1);
    chk("R4 wrap", cnt_lo_o, 0);
    chk("R4 irq", irq_o[0], 1);
    @(negedge clk);
    chk("R4 irq one cycle", irq_o[0], 0);
  endtask

  task automatic t_cmp_live;
    wr(2'b01, 8'd20);
    wr(2'b00, 8'h01);
    ticks(3'b001, 5);
    wr(2'b01, 8'd6);
    ticks(3'b001, 1);
    chk("R5 count", cnt_lo_o, 6);
    ticks(3'b001, 1);
    chk("R5 new cmp used", cnt_lo_o, 0);
    chk("R5 irq", irq_o[0], 1);
  endtask

  task automatic t_full;
    wr(2'b01, 8'hFF);
    wr(2'b00, 8'h01);
    ticks(3'b001, 255);
    chk("R4 full range", cnt_lo_o, 255);
    chk("R4 full no irq", irq_o[0], 0);
    ticks(3'b001, 1);
    chk("R4 full wrap", cnt_lo_o, 0);
    chk("R4 full irq", irq_o[0], 1);
  endtask

  task automatic t_sel;
    wr(2'b00, 8'h05);
    ticks(3'b011, 4);
    chk("R6 other taps ignored", cnt_lo_o, 0);
    ticks(3'b100, 4);
    chk("R6 tap2", cnt_lo_o, 4);
  endtask

  task automatic t_event;
    wr(2'b00, 8'h07);
    tap_en = 3'b111;
    for (int p = 0; p < 3; p++) evt_pulse(3, 3);
    chk("R7 three edges", cnt_lo_o, 3);
    evt_pulse(10, 3);
    chk("R7 long level once", cnt_lo_o, 4);
    tap_en = '0;
    chk("R6 taps ignored in event mode", cnt_lo_o, 4);
  endtask

  task automatic t_pulse;
    wr(2'b01, 8'd2);
    wr(2'b00, 8'h09);
    chk("R8 pulse start", pulse_o[0], 0);
    ticks(3'b001, 3);
    chk("R8 toggle high", pulse_o[0], 1);
    ticks(3'b001, 3);
    chk("R8 toggle low", pulse_o[0], 0);
  endtask

  task automatic t_indep;
    wr(2'b00, 8'h00);
    wr(2'b11, 8'd1);
    wr(2'b10, 8'h03);
    ticks(3'b010, 2);
    chk("R11 hi wrap", cnt_hi_o, 0);
    chk("R11 irq1", irq_o[1], 1);
    chk("R11 irq0 quiet", irq_o[0], 0);
    chk("R11 lo untouched", cnt_lo_o, 0);
    chk("R8 pulse mode off", pulse_o[1], 0);
  endtask

  task automatic t_chain;
    wr(2'b01, 8'd3);
    wr(2'b11, 8'd1);
    wr(2'b00, 8'h10);
    wr(2'b00, 8'h11);
    chk("R9 start lo", cnt_lo_o, 0);
    chk("R9 start hi", cnt_hi_o, 0);
    ticks(3'b011, 255);
    chk("R9 lo top", cnt_lo_o, 255);
    chk("R9 hi before carry", cnt_hi_o, 0);
    ticks(3'b011, 1);
    chk("R9 carry lo", cnt_lo_o, 0);
    chk("R9 carry hi", cnt_hi_o, 1);
    chk("R9 no irq on carry", irq_o[0], 0);
    wr(2'b10, 8'h03);
    chk("R10 ctrl1 ignored", cnt_hi_o, 1);
    ticks(3'b011, 3);
    chk("R9 at full cmp", cnt_lo_o, 3);
    ticks(3'b011, 1);
    chk("R9 clear lo", cnt_lo_o, 0);
    chk("R9 clear hi", cnt_hi_o, 0);
    chk("R9 irq0", irq_o[0], 1);
    chk("R10 irq1 silent", irq_o[1], 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_stop();
    t_match();
    t_cmp_live();
    t_full();
    t_sel();
    t_event();
    t_pulse();
    t_indep();
    t_chain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule